// File: doc/BRIEF.md
# Stepped Transmit Gain Controller

This block chooses the gain step of a transmit output amplifier. The gain is a 5-bit index with 32 levels. Each level is worth roughly 1 dB, so the range covers about 0 to 30 dB. Two external window comparators feed the block. One watches the peak of the sensed output voltage and the other watches the peak of the sensed drive current. Each comparator supplies an "above upper threshold" flag and a "below lower threshold" flag.

An internal divider produces a slow update tick. At the default setting this is one tick every 3200 clocks, which gives 5 kHz from a 16 MHz clock. On each tick the controller raises the index by one step, lowers it by one step or leaves it unchanged. Current limiting comes first. A current peak above its window always forces a step down. A current peak inside its window freezes the gain. Only when the current peak is below its window does the voltage loop decide, stepping up when the voltage is low and down when it is high.

While the transmit mode input is low the loop is idle and the index sits at mid-scale (16). Each transmit burst therefore ramps from 16 toward its settled value. A full ramp from 16 to either end takes 15 or 16 ticks, about 3.2 ms.

Top module: `tx_gain_stepper`

## Requirements
- R1: While reset is asserted, and on the first clock after its release, `gain_idx` equals 16.
- R2: `gain_idx` changes only on an update tick, and by at most one step per tick, while `tx_mode` is high.
- R3: With `cur_lo`=1 and `cur_hi`=0, a tick raises the index by one if `vol_lo`=1 and `vol_hi`=0, lowers it by one if `vol_hi`=1, and holds it if both voltage flags are 0.
- R4: With `cur_hi`=1, a tick lowers the index by one whatever the voltage flags are.
- R5: With both current flags 0 (current inside its window), a tick leaves the index unchanged whatever the voltage flags are.
- R6: The index saturates. An upward request at 31 leaves it at 31, and a downward request at 0 leaves it at 0, with no wrap.
- R7: When `tx_mode` is low, `gain_idx` becomes 16 on the next clock edge and stays at 16 whatever the comparator flags do.
- R8: Each comparator flag passes through two clocked register stages before it is used. The decision at a tick uses the flag values present at the inputs two clock edges before that tick.
- R9: Ticks occur only while `tx_mode` is high. The first tick comes at the TICK_DIV-th rising edge with `tx_mode` high, and further ticks follow every TICK_DIV edges.
- R10: If both flags of one comparator are 1 at once, that comparator is treated as above its upper threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_mode | input | 1 | 1 = transmit session, loop active; 0 = receive, loop idle at mid-scale |
| vol_hi | input | 1 | Voltage peak above upper threshold |
| vol_lo | input | 1 | Voltage peak below lower threshold |
| cur_hi | input | 1 | Current peak above upper threshold |
| cur_lo | input | 1 | Current peak below lower threshold |
| gain_idx | output | 5 | Gain step index for the amplifier, 0..31 |

## Verification
A wrong divider count shifts every gain step by whole cycles, so the first ramp step after `tx_mode` rises shows the error within TICK_DIV clocks. A wrong priority or a wrong sync depth shows as a step up where a hold or a step down was expected. It appears at the first tick after the flags change, or one tick late when the change falls close to that tick. A fault in saturation or in the return to mid-scale shows as a wrap to the opposite end, or a value other than 16, one edge after the event.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  typedef struct packed {
    logic above;
    logic below;
  } win_t;

endpackage

// File: rtl/tgs_sync.sv
module tgs_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stg_d;
      if (g == 0) begin : g_first
        assign stg_d = d_i;
      end else begin : g_next
        assign stg_d = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_d;
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/tgs_tick.sv
module tgs_tick #(
  parameter int DIV = 3200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = run_i && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)       cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tgs_arbiter.sv
module tgs_arbiter
  import tgs_pkg::*;
(
  input  win_t  cur_i,
  input  win_t  vol_i,
  output step_e step_o
);

  always_comb begin
    step_o = STEP_HOLD;
    if (cur_i.above) begin
      step_o = STEP_DOWN;
    end else if (cur_i.below) begin
      if (vol_i.above)      step_o = STEP_DOWN;
      else if (vol_i.below) step_o = STEP_UP;
      else                  step_o = STEP_HOLD;
    end else begin
      step_o = STEP_HOLD;
    end
  end

endmodule

// File: rtl/tgs_gain_reg.sv
module tgs_gain_reg
  import tgs_pkg::*;
#(
  parameter int GW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          tick_i,
  input  step_e         step_i,
  output logic [GW-1:0] gain_o
);

  localparam logic [GW-1:0] GMAX = {GW{1'b1}};
  localparam logic [GW-1:0] GMID = GW'(1 << (GW - 1));

  logic [GW-1:0] gain_q, gain_d;

  always_comb begin
    gain_d = gain_q;
    if (!active_i) begin
      gain_d = GMID;
    end else if (tick_i) begin
      case (step_i)
        STEP_UP:   if (gain_q != GMAX) gain_d = gain_q + 1'b1;
        STEP_DOWN: if (gain_q != '0)   gain_d = gain_q - 1'b1;
        default:   gain_d = gain_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gain_q <= GMID;
    else        gain_q <= gain_d;
  end

  assign gain_o = gain_q;

endmodule

// File: rtl/tx_gain_stepper.sv
module tx_gain_stepper
  import tgs_pkg::*;
#(
  parameter int GW          = 5,
  parameter int TICK_DIV    = 3200,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_mode,
  input  logic          vol_hi,
  input  logic          vol_lo,
  input  logic          cur_hi,
  input  logic          cur_lo,
  output logic [GW-1:0] gain_idx
);

  localparam int NFLAG = 4;

  logic [NFLAG-1:0] flags_raw, flags_s;
  logic             cur_hi_q, cur_lo_q, vol_hi_q, vol_lo_q;
  logic             upd_tick;
  win_t             cur_w, vol_w;
  step_e            step;

  assign flags_raw = {cur_hi, cur_lo, vol_hi, vol_lo};

  tgs_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (flags_raw),
    .q_o   (flags_s)
  );

  assign {cur_hi_q, cur_lo_q, vol_hi_q, vol_lo_q} = flags_s;
  assign cur_w = '{above: cur_hi_q, below: cur_lo_q};
  assign vol_w = '{above: vol_hi_q, below: vol_lo_q};

  tgs_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (tx_mode),
    .tick_o (upd_tick)
  );

  tgs_arbiter u_arb (
    .cur_i  (cur_w),
    .vol_i  (vol_w),
    .step_o (step)
  );

  tgs_gain_reg #(.GW(GW)) u_gain (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (tx_mode),
    .tick_i   (upd_tick),
    .step_i   (step),
    .gain_o   (gain_idx)
  );

endmodule

// File: rtl/tgs_checker.sv
module tgs_checker #(
  parameter int GW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_mode,
  input logic          tick,
  input logic          c_hi,
  input logic          c_lo,
  input logic [GW-1:0] gain
);

  localparam logic [GW-1:0] GMAX = {GW{1'b1}};
  localparam logic [GW-1:0] GMID = GW'(1 << (GW - 1));

  assert_hold_off_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && !tick) |=> (gain == $past(gain)));

  assert_idle_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_mode) |=> (gain == GMID));

  assert_cur_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && tick && c_hi && gain != '0) |=> (gain == $past(gain) - 1'b1));

  assert_cur_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && tick && !c_hi && !c_lo) |=> (gain == $past(gain)));

  assert_no_wrap_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && gain == GMAX) |=> (gain != '0));

  assert_no_wrap_bottom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode && gain == '0) |=> (gain != GMAX));

  assert_no_tick_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_mode) |-> (!tick));

endmodule

bind tx_gain_stepper tgs_checker #(.GW(GW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tx_mode (tx_mode),
  .tick    (upd_tick),
  .c_hi    (cur_hi_q),
  .c_lo    (cur_lo_q),
  .gain    (gain_idx)
);

// File: tb/sim_tx_gain_stepper.sv
module sim_tx_gain_stepper;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 6;
  localparam int GW         = 5;

  logic          clk;
  logic          rst_n;
  logic          tx_mode;
  logic          vol_hi, vol_lo, cur_hi, cur_lo;
  logic [GW-1:0] gain_idx;

  int total;
  int bad;
  string phase;

  // reference model state
  int   m_gain;
  int   m_cnt;
  logic [3:0] m_pipe[$];

  tx_gain_stepper #(.GW(GW), .TICK_DIV(DIV), .SYNC_STAGES(2)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_mode  (tx_mode),
    .vol_hi   (vol_hi),
    .vol_lo   (vol_lo),
    .cur_hi   (cur_hi),
    .cur_lo   (cur_lo),
    .gain_idx (gain_idx)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int decide(logic [3:0] f);
    // f = {cur_hi, cur_lo, vol_hi, vol_lo}; +1 up, -1 down, 0 hold
    if (f[3])      return -1;
    if (!f[2])     return 0;
    if (f[1])      return -1;
    if (f[0])      return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gain = 16;
      m_cnt  = 0;
      m_pipe = '{4'b0, 4'b0};
    end else begin
      logic [3:0] used;
      bit         tk;
      used = m_pipe.pop_front();
      m_pipe.push_back({cur_hi, cur_lo, vol_hi, vol_lo});
      tk = tx_mode && (m_cnt == DIV - 1);
      if (!tx_mode) begin
        m_cnt  = 0;
        m_gain = 16;
      end else begin
        m_cnt = tk ? 0 : m_cnt + 1;
        if (tk) begin
          m_gain = m_gain + decide(used);
          if (m_gain > 31) m_gain = 31;
          if (m_gain < 0)  m_gain = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (int'(gain_idx) != m_gain) begin
        bad++;
        $display("FAIL %s: gain_idx actual=%0d expected=%0d at %0t", phase, gain_idx, m_gain, $time);
      end
    end
  end

  task automatic check_val(string req, int exp);
    total++;
    if (int'(gain_idx) != exp) begin
      bad++;
      $display("FAIL %s: gain_idx actual=%0d expected=%0d", req, gain_idx, exp);
    end
  endtask

  task automatic set_flags(logic chi, logic clo, logic vhi, logic vlo);
    cur_hi = chi; cur_lo = clo; vol_hi = vhi; vol_lo = vlo;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    total = 0; bad = 0;
    phase = "R1";
    rst_n = 1'b0; tx_mode = 1'b0;
    set_flags(0, 0, 0, 0);
    run(3);
    check_val("R1 during reset", 16);
    rst_n = 1'b1;
    run(1);
    check_val("R1 after release", 16);

    // R9: first tick timing, R3 up
    phase = "R9";
    set_flags(0, 1, 0, 1);
    run(4);
    tx_mode = 1'b1;
    run(DIV - 1);
    check_val("R9 no step before tick", 16);
    run(1);
    check_val("R9 first tick step", 17);
    run(DIV);
    check_val("R9 second tick step", 18);

    phase = "R3 up and R6 top";
    run(20 * DIV);
    check_val("R6 saturate at 31", 31);

    phase = "R3 down";
    set_flags(0, 1, 1, 0);
    run(4 * DIV);
    check_val("R3 down steps", 27);

    phase = "R3 hold";
    set_flags(0, 1, 0, 0);
    run(3 * DIV);
    check_val("R3 hold in window", 27);

    phase = "R5";
    set_flags(0, 0, 0, 1);
    run(3 * DIV);
    check_val("R5 current window holds", 27);

    phase = "R4";
    set_flags(1, 0, 0, 1);
    run(2 * DIV);
    check_val("R4 current limit lowers", 25);

    phase = "R10";
    set_flags(0, 1, 1, 1);
    run(2 * DIV);
    check_val("R10 both voltage flags lower", 23);
    set_flags(1, 1, 0, 1);
    run(2 * DIV);
    check_val("R10 both current flags lower", 21);

    phase = "R6 bottom";
    set_flags(1, 0, 0, 0);
    run(30 * DIV);
    check_val("R6 saturate at 0", 0);

    phase = "R7";
    tx_mode = 1'b0;
    run(1);
    check_val("R7 back to mid", 16);
    for (int i = 0; i < 20; i++) begin
      set_flags(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      run(1);
    end
    check_val("R7 flags ignored while idle", 16);

    // R8: flag changes close to the tick
    phase = "R8";
    set_flags(0, 1, 0, 1);
    tx_mode = 1'b1;
    run(DIV - 1);
    set_flags(1, 0, 0, 0);  // one edge before tick: not yet visible
    run(1);
    check_val("R8 stale flags used", 17);
    run(DIV);
    check_val("R8 new flags used", 16);

    phase = "R2 random";
    for (int i = 0; i < 400; i++) begin
      set_flags(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      if (($urandom % 50) == 0) tx_mode = ~tx_mode;
      run(1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule